// File: doc/BRIEF.md
# Multi-channel DMA request router

This block sits between a multi-buffer serial engine and a DMA controller. It holds a set of independently programmed DMA channels, eight by default. Each channel is bound to one buffer slot of the engine's buffer array. Whenever the engine reports that a slot has finished a transmit or a receive word, every channel bound to that slot may raise a request. A channel steers its transmit request and its receive request onto any of sixteen shared request lines. Each direction has its own 4-bit route field, which feeds a one-hot decoder. The decoded outputs of all channels are OR-merged and registered, so each line carries a one-cycle pulse.

Each channel also counts the words it still has to move. In short-count mode a channel moves 1 to 32 words. In long-count mode it moves up to 65535 words through the same slot. When the last word is requested, the channel disarms itself and raises a sticky completion flag. A configuration write to a channel re-arms it.

Top module: `dma_req_router`

## Requirements
- R1: While reset is held and after it is released, `dma_req` and `ch_done` are all zero and every channel is disarmed, so no event produces a request.
- R2: A cycle with `cfg_we` high loads the channel selected by `cfg_ch` with its slot index, both direction enables, both route fields, the count mode and the count. If the loaded count is non-zero, the write also clears that channel's `ch_done` bit.
- R3: An event (`ev_valid` high) whose `ev_buf` equals a channel's slot index, with `ev_tx` high and that channel's transmit enable set, raises bit `tx route` of `dma_req`. The route is a binary line number from 0 to 15. An event with `ev_rx` high does the same on the receive route when the receive enable is set.
- R4: One event with both `ev_tx` and `ev_rx` high raises the transmit and the receive line of a channel together. If both routes name the same line, one line is raised.
- R5: A direction whose enable is clear raises nothing. An event whose slot index matches no channel raises nothing.
- R6: Requests from several channels are OR-merged per line. Two sources on the same line in the same cycle give a single pulse, and sources on different lines give pulses on each line.
- R7: A request appears on `dma_req` in the cycle right after the event is sampled and lasts exactly one cycle unless a new event follows.
- R8: With `cfg_ext` low, the channel's word budget is `cfg_count[4:0]` + 1 (1 to 32), and the upper count bits are ignored. An event that makes the channel raise at least one request consumes one word. An event that raises nothing consumes nothing.
- R9: With `cfg_ext` high, the word budget is the full 16-bit `cfg_count`. A budget of zero leaves the channel disarmed with `ch_done` set right after the write.
- R10: The event that consumes the last word still raises its requests. From the next cycle on, the channel is disarmed and its `ch_done` bit is set, and later events on its slot raise nothing.
- R11: If a configuration write and an event address the same channel in one cycle, the write takes effect and that channel ignores the event.
- R12: A `ch_done` bit stays set until its channel is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_ch | input | 3 | Channel selected by the write |
| cfg_buf | input | 7 | Buffer slot index bound to the channel |
| cfg_tx_en | input | 1 | Transmit request enable |
| cfg_rx_en | input | 1 | Receive request enable |
| cfg_tx_map | input | 4 | Line number for transmit requests |
| cfg_rx_map | input | 4 | Line number for receive requests |
| cfg_ext | input | 1 | 1: long 16-bit count, 0: short 5-bit count plus one |
| cfg_count | input | 16 | Word budget field |
| ev_valid | input | 1 | A buffer slot finished a word this cycle |
| ev_buf | input | 7 | Slot index of the event |
| ev_tx | input | 1 | The event includes a transmit completion |
| ev_rx | input | 1 | The event includes a receive completion |
| dma_req | output | 16 | Registered one-cycle request pulses, one per line |
| ch_done | output | 8 | Sticky per-channel budget-exhausted flags |

## Verification
A wrong slot index, enable or route held inside a channel shows on the very next cycle after a matching event: a pulse appears on the wrong line, on no line, or on an extra line. A count register that is off by one stays invisible until the budget runs out. At that point it shows as one pulse too many or too few, and as `ch_done` rising one event early or late. For that reason, the short budgets are walked to the end and one event past it. A write that fails to override a same-cycle event shows as a stray pulse on the old route in the cycle after the write.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  // Width of the short-mode count field; its budget is field + 1.
  localparam int unsigned SHORT_CNT_W = 5;

  typedef enum logic {
    CNT_SHORT = 1'b0,
    CNT_LONG  = 1'b1
  } cnt_mode_e;

endpackage

// File: rtl/dmr_rst_sync.sv
module dmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dmr_line_decoder.sv
module dmr_line_decoder #(
  parameter int unsigned LINES = 16,
  localparam int unsigned MAP_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [MAP_W-1:0] sel,
  output logic [LINES-1:0] lines
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = en && (sel == MAP_W'(i));
  end

  AST_DEC_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lines)); // R3

  AST_DEC_EN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(lines) == 1); // R3

endmodule

// File: rtl/dmr_channel.sv
module dmr_channel #(
  parameter int unsigned BUF_W = 7,
  parameter int unsigned LINES = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned MAP_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUF_W-1:0] cfg_buf,
  input  logic             cfg_tx_en,
  input  logic             cfg_rx_en,
  input  logic [MAP_W-1:0] cfg_tx_map,
  input  logic [MAP_W-1:0] cfg_rx_map,
  input  logic             cfg_ext,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             ev_valid,
  input  logic [BUF_W-1:0] ev_buf,
  input  logic             ev_tx,
  input  logic             ev_rx,
  output logic [LINES-1:0] tx_lines,
  output logic [LINES-1:0] rx_lines,
  output logic             done
);
  import dmr_pkg::*;

  logic [BUF_W-1:0] buf_q,    buf_d;
  logic             tx_en_q,  tx_en_d;
  logic             rx_en_q,  rx_en_d;
  logic [MAP_W-1:0] tx_map_q, tx_map_d;
  logic [MAP_W-1:0] rx_map_q, rx_map_d;
  logic [CNT_W-1:0] cnt_q,    cnt_d;
  logic             done_q,   done_d;

  logic             slot_hit;
  logic             tx_fire;
  logic             rx_fire;
  logic             issue;
  logic             upd;
  logic [CNT_W-1:0] load_cnt;
  cnt_mode_e        mode;

  assign mode     = cnt_mode_e'(cfg_ext);
  assign load_cnt = (mode == CNT_LONG) ? cfg_count
                  : CNT_W'(cfg_count[SHORT_CNT_W-1:0]) + CNT_W'(1);

  // A write to this channel overrides an event in the same cycle.
  assign slot_hit = ev_valid && (ev_buf == buf_q) && !wr;
  assign tx_fire  = slot_hit && ev_tx && tx_en_q;
  assign rx_fire  = slot_hit && ev_rx && rx_en_q;
  assign issue    = tx_fire || rx_fire;
  assign upd      = wr || issue;

  always_comb begin
    buf_d    = buf_q;
    tx_en_d  = tx_en_q;
    rx_en_d  = rx_en_q;
    tx_map_d = tx_map_q;
    rx_map_d = rx_map_q;
    cnt_d    = cnt_q;
    done_d   = done_q;
    if (wr) begin
      buf_d    = cfg_buf;
      tx_map_d = cfg_tx_map;
      rx_map_d = cfg_rx_map;
      cnt_d    = load_cnt;
      if (load_cnt == '0) begin
        tx_en_d = 1'b0;
        rx_en_d = 1'b0;
        done_d  = 1'b1;
      end else begin
        tx_en_d = cfg_tx_en;
        rx_en_d = cfg_rx_en;
        done_d  = 1'b0;
      end
    end else if (issue) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        tx_en_d = 1'b0;
        rx_en_d = 1'b0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_map_q <= '0;
      rx_map_q <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else if (upd) begin
      buf_q    <= buf_d;
      tx_en_q  <= tx_en_d;
      rx_en_q  <= rx_en_d;
      tx_map_q <= tx_map_d;
      rx_map_q <= rx_map_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
    end
  end

  dmr_line_decoder #(.LINES(LINES)) u_tx_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tx_fire),
    .sel   (tx_map_q),
    .lines (tx_lines)
  );

  dmr_line_decoder #(.LINES(LINES)) u_rx_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (rx_fire),
    .sel   (rx_map_q),
    .lines (rx_lines)
  );

  assign done = done_q;

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !tx_en_q && !rx_en_q); // R10

  AST_LAST_WORD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && issue && cnt_q == CNT_W'(1)) |=> done_q); // R10

  AST_ARMED_HAS_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_q || rx_en_q) |-> cnt_q != '0); // R8

  AST_TX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_q |-> tx_lines == '0); // R5

  AST_RX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_q |-> rx_lines == '0); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr) |=> done_q); // R12

endmodule

// File: rtl/dmr_req_merge.sv
module dmr_req_merge #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned LINES  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] ch_tx [NUM_CH],
  input  logic [LINES-1:0] ch_rx [NUM_CH],
  output logic [LINES-1:0] req
);

  logic [LINES-1:0] merged;
  logic [LINES-1:0] req_q;

  always_comb begin
    merged = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      merged = merged | ch_tx[c] | ch_rx[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= merged;
    end
  end

  assign req = req_q;

  AST_PULSE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (merged != '0) |=> (req_q != '0)); // R6

  AST_NO_SOURCE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (merged == '0) |=> (req_q == '0)); // R7

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned LINES  = 16,
  parameter int unsigned BUF_W  = 7,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned MAP_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [BUF_W-1:0]  cfg_buf,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic [MAP_W-1:0]  cfg_tx_map,
  input  logic [MAP_W-1:0]  cfg_rx_map,
  input  logic              cfg_ext,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              ev_valid,
  input  logic [BUF_W-1:0]  ev_buf,
  input  logic              ev_tx,
  input  logic              ev_rx,
  output logic [LINES-1:0]  dma_req,
  output logic [NUM_CH-1:0] ch_done
);

  logic             rst_n_s;
  logic [LINES-1:0] ch_tx [NUM_CH];
  logic [LINES-1:0] ch_rx [NUM_CH];
  logic             ev_seen_q;

  dmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_sel;
    assign wr_sel = cfg_we && (cfg_ch == CH_W'(g));

    dmr_channel #(
      .BUF_W (BUF_W),
      .LINES (LINES),
      .CNT_W (CNT_W)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .wr         (wr_sel),
      .cfg_buf    (cfg_buf),
      .cfg_tx_en  (cfg_tx_en),
      .cfg_rx_en  (cfg_rx_en),
      .cfg_tx_map (cfg_tx_map),
      .cfg_rx_map (cfg_rx_map),
      .cfg_ext    (cfg_ext),
      .cfg_count  (cfg_count),
      .ev_valid   (ev_valid),
      .ev_buf     (ev_buf),
      .ev_tx      (ev_tx),
      .ev_rx      (ev_rx),
      .tx_lines   (ch_tx[g]),
      .rx_lines   (ch_rx[g]),
      .done       (ch_done[g])
    );
  end

  dmr_req_merge #(
    .NUM_CH (NUM_CH),
    .LINES  (LINES)
  ) u_merge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ch_tx (ch_tx),
    .ch_rx (ch_rx),
    .req   (dma_req)
  );

  // Registered copy of the event strobe, used only by the checks below.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ev_seen_q <= 1'b0;
    end else begin
      ev_seen_q <= ev_valid && (ev_tx || ev_rx);
    end
  end

  AST_REQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dma_req != '0) |-> ev_seen_q); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |-> (dma_req == '0 && ch_done == '0)); // R1

endmodule

// File: tb/sim_dma_req_router.sv
module sim_dma_req_router;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_ch;
  logic [6:0]  cfg_buf;
  logic        cfg_tx_en;
  logic        cfg_rx_en;
  logic [3:0]  cfg_tx_map;
  logic [3:0]  cfg_rx_map;
  logic        cfg_ext;
  logic [15:0] cfg_count;
  logic        ev_valid;
  logic [6:0]  ev_buf;
  logic        ev_tx;
  logic        ev_rx;
  logic [15:0] dma_req;
  logic [7:0]  ch_done;

  int n_run;
  int n_fail;
  bit finished;

  dma_req_router u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_buf    (cfg_buf),
    .cfg_tx_en  (cfg_tx_en),
    .cfg_rx_en  (cfg_rx_en),
    .cfg_tx_map (cfg_tx_map),
    .cfg_rx_map (cfg_rx_map),
    .cfg_ext    (cfg_ext),
    .cfg_count  (cfg_count),
    .ev_valid   (ev_valid),
    .ev_buf     (ev_buf),
    .ev_tx      (ev_tx),
    .ev_rx      (ev_rx),
    .dma_req    (dma_req),
    .ch_done    (ch_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector layout: [31:24] slot, [17] tx, [16] rx, [15:0] expected lines.
  localparam logic [31:0] VEC [10] = '{
    {8'd5,  6'd0, 1'b1, 1'b0, 16'h0008},  // R3 tx route 3
    {8'd5,  6'd0, 1'b0, 1'b1, 16'h0200},  // R3 rx route 9
    {8'd5,  6'd0, 1'b1, 1'b1, 16'h0208},  // R4 both directions
    {8'd10, 6'd0, 1'b1, 1'b0, 16'h0008},  // R3 second channel
    {8'd10, 6'd0, 1'b0, 1'b1, 16'h0008},  // R5 ch1 rx off, ch3 rx on
    {8'd10, 6'd0, 1'b1, 1'b1, 16'h0008},  // R6 two channels, one line
    {8'd20, 6'd0, 1'b1, 1'b0, 16'h0000},  // R5 tx disabled
    {8'd20, 6'd0, 1'b0, 1'b1, 16'h8000},  // R3 top line
    {8'd0,  6'd0, 1'b1, 1'b1, 16'h0000},  // R5 unconfigured channels
    {8'd7,  6'd0, 1'b1, 1'b1, 16'h0000}   // R5 no slot match
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int ch, input int bufi, input bit tx, input bit rx,
                           input int tmap, input int rmap, input bit ext, input int cnt);
    cfg_we     = 1'b1;
    cfg_ch     = 3'(ch);
    cfg_buf    = 7'(bufi);
    cfg_tx_en  = tx;
    cfg_rx_en  = rx;
    cfg_tx_map = 4'(tmap);
    cfg_rx_map = 4'(rmap);
    cfg_ext    = ext;
    cfg_count  = 16'(cnt);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Returns at the negedge after the capturing edge: the pulse is visible.
  task automatic send_ev(input int bufi, input bit tx, input bit rx);
    ev_valid = 1'b1;
    ev_buf   = 7'(bufi);
    ev_tx    = tx;
    ev_rx    = rx;
    @(negedge clk);
    ev_valid = 1'b0;
    ev_tx    = 1'b0;
    ev_rx    = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_buf = '0;
    cfg_tx_en = 1'b0; cfg_rx_en = 1'b0; cfg_tx_map = '0; cfg_rx_map = '0;
    cfg_ext = 1'b0; cfg_count = '0; ev_valid = 1'b0; ev_buf = '0;
    ev_tx = 1'b0; ev_rx = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset req", 32'(dma_req), 32'h0);
    check("R1 reset done", 32'(ch_done), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {16'(ch_done), dma_req}, 32'h0);
    send_ev(0, 1'b1, 1'b1);
    check("R1 disarmed after reset", 32'(dma_req), 32'h0);

    // Table channels, long budgets.
    write_cfg(0, 5,  1, 1, 3, 9,  1, 1000);
    write_cfg(1, 10, 1, 0, 3, 4,  1, 1000);
    write_cfg(2, 20, 0, 1, 0, 15, 1, 1000);
    write_cfg(3, 10, 0, 1, 0, 3,  1, 1000);
    check("R2 armed not done", 32'(ch_done), 32'h0);

    for (int i = 0; i < 10; i++) begin
      send_ev(int'(VEC[i][31:24]), VEC[i][17], VEC[i][16]);
      check($sformatf("R3 vector %0d", i), 32'(dma_req), 32'(VEC[i][15:0]));
    end

    // R7: one-cycle pulse.
    send_ev(5, 1'b1, 1'b0);
    check("R7 pulse present", 32'(dma_req), 32'h0008);
    @(negedge clk);
    check("R7 pulse gone", 32'(dma_req), 32'h0);

    // R4: both routes on the same line.
    write_cfg(2, 20, 1, 1, 15, 15, 1, 1000);
    send_ev(20, 1'b1, 1'b1);
    check("R4 shared route", 32'(dma_req), 32'h8000);

    // R8, R10, R12: short budget of 3 (field 2).
    write_cfg(4, 30, 1, 0, 6, 1, 0, 2);
    send_ev(30, 1'b0, 1'b1);
    check("R8 no request no word", 32'(dma_req), 32'h0);
    for (int k = 0; k < 3; k++) begin
      send_ev(30, 1'b1, 1'b0);
      check($sformatf("R8 word %0d", k), 32'(dma_req), 32'h0040);
      if (k < 2) check("R10 not yet done", 32'(ch_done[4]), 32'h0);
    end
    check("R10 done after last", 32'(ch_done[4]), 32'h1);
    send_ev(30, 1'b1, 1'b0);
    check("R10 exhausted silent", 32'(dma_req), 32'h0);
    repeat (3) @(negedge clk);
    check("R12 done sticky", 32'(ch_done[4]), 32'h1);
    write_cfg(4, 30, 1, 0, 6, 1, 0, 0);
    check("R2 rewrite clears done", 32'(ch_done[4]), 32'h0);
    send_ev(30, 1'b1, 1'b0);
    check("R8 budget of one", 32'(dma_req), 32'h0040);
    check("R10 single word done", 32'(ch_done[4]), 32'h1);

    // R8: upper bits ignored in short mode (0x21 -> 2 words).
    write_cfg(6, 50, 1, 0, 10, 0, 0, 16'h0021);
    send_ev(50, 1'b1, 1'b0);
    check("R8 short word 1", 32'(dma_req), 32'h0400);
    send_ev(50, 1'b1, 1'b0);
    check("R8 short word 2", 32'(dma_req), 32'h0400);
    send_ev(50, 1'b1, 1'b0);
    check("R8 short exhausted", 32'(dma_req), 32'h0);

    // R9: long budget of zero.
    write_cfg(5, 40, 1, 1, 7, 8, 1, 0);
    check("R9 zero budget done", 32'(ch_done[5]), 32'h1);
    send_ev(40, 1'b1, 1'b1);
    check("R9 zero budget silent", 32'(dma_req), 32'h0);

    // R11: write and event on the same channel in one cycle.
    write_cfg(7, 60, 1, 0, 11, 0, 1, 5);
    cfg_we = 1'b1; cfg_ch = 3'd7; cfg_buf = 7'd61; cfg_tx_en = 1'b1;
    cfg_rx_en = 1'b0; cfg_tx_map = 4'd12; cfg_rx_map = 4'd0;
    cfg_ext = 1'b1; cfg_count = 16'd5;
    ev_valid = 1'b1; ev_buf = 7'd60; ev_tx = 1'b1; ev_rx = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; ev_valid = 1'b0; ev_tx = 1'b0;
    check("R11 event dropped", 32'(dma_req), 32'h0);
    send_ev(60, 1'b1, 1'b0);
    check("R11 old slot gone", 32'(dma_req), 32'h0);
    send_ev(61, 1'b1, 1'b0);
    check("R11 new route live", 32'(dma_req), 32'h1000);

    // R6: different lines from different channels together.
    write_cfg(1, 5, 1, 0, 2, 0, 1, 100);
    send_ev(5, 1'b1, 1'b0);
    check("R6 two lines", 32'(dma_req), 32'h000C);

    finish_run();
  end

endmodule